// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block steers instruction fetch for a short in-order pipeline that has exactly one branch delay slot. It holds the address being fetched this cycle and the address of the instruction that reached execute one cycle later. A decoder outside the block looks at the executing instruction. It reports whether that instruction is an unconditional jump and, if so, where the jump goes. The sequencer then picks the next fetch address. A jump only changes where the following fetch goes. The instruction already fetched behind the jump still runs.

A jump may sit in the delay slot of another jump. No trap is raised. Each jump simply redirects the fetch that follows it. Back-to-back jumps therefore make fetch alternate between targets. The pair "jump to T, then jump to the address after the pair" runs the single instruction at T out of line and then returns. A stall input freezes the whole sequencer. A redirect that is waiting in execute is kept and takes effect when the stall lifts.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fetch_addr` equals `RESET_VEC` (default 0x100) and `ex_valid` is 0.
- R2: On each unstalled clock where execute holds a valid non-jump, `fetch_addr` advances by 4. On every unstalled clock, `ex_pc` takes the previous `fetch_addr` and `ex_valid` becomes 1.
- R3: On an unstalled clock where execute holds a valid jump (`ex_is_jump`=1), the next `fetch_addr` is `ex_target` with its low two bits forced to zero. For example, a target of 0x1AB gives 0x1A8.
- R4: When `ex_valid` is 0, `ex_is_jump` is ignored and `fetch_addr` advances by 4.
- R5: While `stall` is 1, `fetch_addr`, `ex_pc` and `ex_valid` hold their values. A jump held in execute during a stall still redirects fetch on the first unstalled clock.
- R6: Out-of-line execute works as follows. The word at A holds "jump T" and the word at A+4 holds "jump A+8". The executed addresses are then A, A+4, T, A+8, A+12 and onward.
- R7: A chain of jumps in each other's delay slots is handled in order. Take jumps x0→x3, x1→x2, x2→x3, x3→x4, x4→x5, x5→x6, x6→x7, where xN = 0x100 + 4N and every other word is a non-jump. The executed sequence is then x0,x1,x3,x2,x4,x3,x5,x4,x6,x5,x7,x6,x7,x7,x8,x9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze fetch and execute state |
| ex_is_jump | input | 1 | Decoded: the instruction in execute is an unconditional jump |
| ex_target | input | AW | Decoded jump destination of the instruction in execute |
| fetch_addr | output | AW | Address fetched this cycle |
| ex_pc | output | AW | Address of the instruction in execute |
| ex_valid | output | 1 | Execute holds a real instruction (not the post-reset bubble) |

## Verification
A stall and a pending redirect can fall in the same cycle, as can a jump in execute and a jump in the slot behind it. The bench stalls for three cycles while a jump sits in execute. It checks that nothing moves, and then that the very next fetch after release is the jump target. Chained and out-of-line jump programs are run from a small instruction model. Each executed address is compared with the ordering worked out by hand from the one-slot rule. A jump presented during the post-reset bubble is judged by the fetch address that follows it.

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq #(
  parameter int          AW          = 32,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_VEC   = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          ex_is_jump,
  input  logic [AW-1:0] ex_target,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] ex_pc,
  output logic          ex_valid
);

  localparam logic [AW-1:0] STEP     = AW'(INSTR_BYTES);
  localparam logic [AW-1:0] LOW_MASK = AW'(INSTR_BYTES - 1);
  localparam logic [AW-1:0] RST_PC   = AW'(RESET_VEC);

  logic [AW-1:0] fetch_q, expc_q, tgt_aligned, seq_pc, next_fetch;
  logic          exv_q, take_jump;

  assign tgt_aligned = ex_target & ~LOW_MASK;
  assign seq_pc      = fetch_q + STEP;
  assign take_jump   = exv_q & ex_is_jump;
  assign next_fetch  = take_jump ? tgt_aligned : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= RST_PC;
      expc_q  <= '0;
      exv_q   <= 1'b0;
    end else if (!stall) begin
      fetch_q <= next_fetch;
      expc_q  <= fetch_q;
      exv_q   <= 1'b1;
    end
  end

  assign fetch_addr = fetch_q;
  assign ex_pc      = expc_q;
  assign ex_valid   = exv_q;

  p_pipe_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (ex_valid && ex_pc == $past(fetch_addr)));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ex_valid && !ex_is_jump) |=> (fetch_addr == $past(fetch_addr) + STEP));

  p_jump_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && ex_valid && ex_is_jump) |=> (fetch_addr == ($past(ex_target) & ~LOW_MASK)));

  p_bubble_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !ex_valid) |=> (fetch_addr == $past(fetch_addr) + STEP));

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(fetch_addr) && $stable(ex_pc) && $stable(ex_valid)));

  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> ex_valid);

endmodule

// File: tb/dslot_fetch_seq_bench.sv
module dslot_fetch_seq_bench;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic ex_is_jump;
  logic [31:0] ex_target, fetch_addr, ex_pc;
  logic ex_valid;

  logic        rom_j [16];
  logic [31:0] rom_t [16];
  logic        ovr_en = 1'b0;
  logic        ovr_j = 1'b0;
  logic [31:0] ovr_t = '0;
  logic [3:0]  ex_idx;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  assign ex_idx     = 4'((ex_pc - RV) >> 2);
  assign ex_is_jump = ovr_en ? ovr_j : rom_j[ex_idx];
  assign ex_target  = ovr_en ? ovr_t : rom_t[ex_idx];

  dslot_fetch_seq u_dslot_fetch_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .ex_is_jump(ex_is_jump), .ex_target(ex_target),
    .fetch_addr(fetch_addr), .ex_pc(ex_pc), .ex_valid(ex_valid));

  function automatic logic [31:0] wa(input int i);
    return RV + 32'(4 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_rom(input int scen);
    for (int i = 0; i < 16; i++) begin
      rom_j[i] = 1'b0;
      rom_t[i] = '0;
    end
    if (scen == 0) begin
      rom_j[0] = 1; rom_t[0] = wa(3);
      rom_j[1] = 1; rom_t[1] = wa(2);
      rom_j[2] = 1; rom_t[2] = wa(3);
      rom_j[3] = 1; rom_t[3] = wa(4);
      rom_j[4] = 1; rom_t[4] = wa(5);
      rom_j[5] = 1; rom_t[5] = wa(6);
      rom_j[6] = 1; rom_t[6] = wa(7);
    end else if (scen == 1) begin
      rom_j[0] = 1; rom_t[0] = wa(12);
      rom_j[1] = 1; rom_t[1] = wa(2);
    end
  endtask

  task automatic do_reset(input int scen);
    @(negedge clk);
    rst_n = 1'b0; stall = 1'b0; ovr_en = 1'b0;
    load_rom(scen);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // {scenario, expected executed word index}; scenario 0 = chain (R7), 1 = out-of-line (R6)
  localparam logic [7:0] VEC [22] = '{
    8'h00, 8'h01, 8'h03, 8'h02, 8'h04, 8'h03, 8'h05, 8'h04,
    8'h06, 8'h05, 8'h07, 8'h06, 8'h07, 8'h07, 8'h08, 8'h09,
    8'h10, 8'h11, 8'h1C, 8'h12, 8'h13, 8'h14 };

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int cur;
    load_rom(2);
    // R1 reset state
    #12;
    chk("R1 fetch in reset", fetch_addr, RV);
    chk("R1 valid in reset", 32'(ex_valid), 0);
    do_reset(2);
    chk("R1 fetch after reset", fetch_addr, RV);
    chk("R1 bubble after reset", 32'(ex_valid), 0);

    // Table walk: R6 and R7 execute orderings
    cur = -1;
    foreach (VEC[k]) begin
      if (int'(VEC[k][7:4]) != cur) begin
        cur = int'(VEC[k][7:4]);
        do_reset(cur);
      end
      step();
      chk(cur == 0 ? "R7 chain order" : "R6 out-of-line order", ex_pc, wa(int'(VEC[k][3:0])));
      chk(cur == 0 ? "R7 valid" : "R6 valid", 32'(ex_valid), 1);
    end

    // R2 sequential run over non-jumps
    do_reset(2);
    for (int n = 1; n <= 5; n++) begin
      step();
      chk("R2 fetch +4", fetch_addr, wa(n));
      chk("R2 ex_pc follows fetch", ex_pc, wa(n - 1));
    end

    // R4 jump presented during the bubble is ignored
    do_reset(2);
    ovr_en = 1; ovr_j = 1; ovr_t = 32'h0000_0200;
    step();
    chk("R4 bubble jump ignored", fetch_addr, wa(1));
    ovr_en = 0;

    // R3 misaligned target is word aligned
    do_reset(2);
    step();
    ovr_en = 1; ovr_j = 1; ovr_t = 32'h0000_01AB;
    step();
    chk("R3 aligned target", fetch_addr, 32'h0000_01A8);
    ovr_en = 0;
    step();
    chk("R3 sequential after target", fetch_addr, 32'h0000_01AC);

    // R5 stall with a jump waiting in execute
    do_reset(1);
    step();
    chk("R5 pre-stall ex", ex_pc, wa(0));
    stall = 1'b1;
    for (int s = 0; s < 3; s++) begin
      step();
      chk("R5 fetch frozen", fetch_addr, wa(1));
      chk("R5 ex frozen", ex_pc, wa(0));
    end
    stall = 1'b0;
    step();
    chk("R5 redirect kept", fetch_addr, wa(12));
    chk("R5 slot executes", ex_pc, wa(1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule